// File: doc/BRIEF.md
# Wake-up Edge Detection Controller

This block watches a bank of external wake-up pins, arranged in groups of eight, and turns the edges it sees into sticky event bits. Each pin can be set to react to a rising edge, a falling edge or both edges. A detected edge sets that pin's event bit, and the bit stays set until software clears it. Software can only clear an event bit by writing a 1 to it. The block never raises an interrupt on a pin level. It only samples the pins, compares each one with its value one cycle earlier, and stores the result.

Each group has three byte registers on a simple write-strobe register bus with combinational read data: an event (status) register, an edge-select register and a dual-edge register. Every event bit is also driven out as a level, so a downstream interrupt controller can use it directly. The bits of each group are also ORed into one summary line per group. Group numbers start at 1.

Software should clear a group's event bits after it changes either mode register. A mode change can leave a stale event behind.

The pins can pass through a two-flop synchronizer inside the block, chosen by a parameter. A second parameter turns on a compatibility mode. In that mode, groups 7, 10 and 12 treat their falling-edge select bit as a request for dual-edge detection.

Top module: `wkup_edge_ctrl`

## Requirements
- R1: After reset, every event, edge-select and dual-edge register reads 0, and `irq_bits` and `irq_grp` are all 0.
- R2: When the dual-edge bit is 0, an edge-select bit of 0 makes the pin react to rising edges only, and a value of 1 makes it react to falling edges only.
- R3: When a pin's dual-edge bit is 1, both edges set its event bit, whatever the value of its edge-select bit.
- R4: An event bit stays 1 until a bus write to the event register carries a 1 in that bit position. Writing a 0 leaves the bit unchanged.
- R5: If an edge is detected in the same cycle as a write-1 clear of the same bit, the bit stays 1. Other bits in that write are still cleared.
- R6: The address is {bank[1:0], offset[5:0]}. Bank 0 holds the event registers, bank 1 the edge-select registers and bank 2 the dual-edge registers. Group g sits at offset g-1 when g is 4 or less, and at offset 4*(g-4) when g is 5 or more. Any other address reads 0 and ignores writes.
- R7: `irq_bits[(g-1)*8+b]` equals event bit b of group g at all times, and `irq_grp[g-1]` is the OR of that group's eight event bits.
- R8: With LEGACY_BOTH=1, groups 7, 10 and 12 treat an edge-select bit of 1 as dual-edge detection. All other groups, and every group when LEGACY_BOTH=0, follow R2.
- R9: With SYNC_EN=1, a pin change that lands before clock edge k sets its event bit at edge k+2, so the bit is visible after edge k+2. A pin that does not change sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NUM_GROUPS*8 | Wake-up pins; group g uses bits (g-1)*8 to (g-1)*8+7 |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at `bus_addr`, combinational |
| irq_bits | output | NUM_GROUPS*8 | Event level for each pin |
| irq_grp | output | NUM_GROUPS | OR of the event bits of each group |

## Verification
The assertions assume that reset starts with the pins low. They also assume that a pin holds each level for at least the synchronizer depth plus one cycle, so that every change shows up as a single, clean edge after synchronization. The stimulus moves one pin at a time and holds each level for four cycles before it samples. It returns every pin to 0 before it moves on to the next group or bit. Mode registers change only while the pins are still, and each event register is cleared before the next edge, so no stale events carry over between sweep steps.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int unsigned GRP_W = 8;

    typedef enum logic [1:0] {
        BANK_EVT  = 2'd0,
        BANK_EDGE = 2'd1,
        BANK_DUAL = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    // Offset of a 1-based group inside a bank: packed for groups 1..4,
    // then a stride of four bytes starting at offset 4 for group 5.
    function automatic int unsigned grp_offset(input int unsigned g);
        return (g <= 4) ? (g - 1) : (4 * (g - 4));
    endfunction

    function automatic bit is_compat_group(input int unsigned g);
        return (g == 7) || (g == 10) || (g == 12);
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter bit          ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (ENABLE) begin : g_sync
            logic [WIDTH-1:0] stage1_q;
            logic [WIDTH-1:0] stage2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1_q <= '0;
                    stage2_q <= '0;
                end else begin
                    stage1_q <= d;
                    stage2_q <= stage1_q;
                end
            end
            assign q = stage2_q;
        end else begin : g_bypass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/wkup_group.sv
module wkup_group
    import wkup_pkg::*;
#(
    parameter int unsigned GROUP_NUM   = 1,
    parameter bit          LEGACY_BOTH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] pin_s,
    input  logic             wr_evt,
    input  logic             wr_edge,
    input  logic             wr_dual,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] evt_o,
    output logic [GRP_W-1:0] edge_o,
    output logic [GRP_W-1:0] dual_o
);
    localparam bit COMPAT = LEGACY_BOTH && is_compat_group(GROUP_NUM);

    logic [GRP_W-1:0] prev_q;
    logic [GRP_W-1:0] evt_q;
    logic [GRP_W-1:0] edge_q;
    logic [GRP_W-1:0] dual_q;
    logic [GRP_W-1:0] rise;
    logic [GRP_W-1:0] fall;
    logic [GRP_W-1:0] dual_eff;
    logic [GRP_W-1:0] det;
    logic [GRP_W-1:0] clr_mask;

    always_comb begin
        rise     = pin_s & ~prev_q;
        fall     = ~pin_s & prev_q;
        dual_eff = dual_q | (COMPAT ? edge_q : '0);
        det      = (dual_eff & (rise | fall))
                 | (~dual_eff & edge_q & fall)
                 | (~dual_eff & ~edge_q & rise);
        clr_mask = wr_evt ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            evt_q  <= '0;
            edge_q <= '0;
            dual_q <= '0;
        end else begin
            prev_q <= pin_s;
            evt_q  <= (evt_q & ~clr_mask) | det;
            if (wr_edge) edge_q <= wdata;
            if (wr_dual) dual_q <= wdata;
        end
    end

    assign evt_o  = evt_q;
    assign edge_o = edge_q;
    assign dual_o = dual_q;

    // R4: a set bit only drops when the same bit was written with 1
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(evt_q) & ~$past(clr_mask)) & ~evt_q) == 8'h00));

    // R5: a detected edge always leaves its event bit set, even under clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det) & ~evt_q) == 8'h00));

    // R9: an event bit rises only from a detected edge
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(det)) == 8'h00));

    // R6: an edge-select write lands in its register
    p_edge_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge |=> (edge_q == $past(wdata)));

    // R6: a dual-edge write lands in its register
    p_dual_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dual |=> (dual_q == $past(wdata)));
endmodule

// File: rtl/wkup_edge_ctrl.sv
module wkup_edge_ctrl
    import wkup_pkg::*;
#(
    parameter int unsigned NUM_GROUPS  = 12,
    parameter bit          SYNC_EN     = 1'b1,
    parameter bit          LEGACY_BOTH = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*GRP_W-1:0] pin_in,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic [NUM_GROUPS*GRP_W-1:0] irq_bits,
    output logic [NUM_GROUPS-1:0]       irq_grp
);
    localparam int unsigned NPINS = NUM_GROUPS * GRP_W;

    logic [NPINS-1:0]  pin_s;
    bank_e             bank;
    logic [5:0]        offs;
    logic [NUM_GROUPS-1:0] hit;
    logic [GRP_W-1:0]  evt_a  [NUM_GROUPS];
    logic [GRP_W-1:0]  edge_a [NUM_GROUPS];
    logic [GRP_W-1:0]  dual_a [NUM_GROUPS];

    assign bank = bank_e'(bus_addr[7:6]);
    assign offs = bus_addr[5:0];

    wkup_sync #(.WIDTH(NPINS), .ENABLE(SYNC_EN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam logic [5:0] OFF = 6'(grp_offset(g + 1));
            assign hit[g] = (offs == OFF);

            wkup_group #(.GROUP_NUM(g + 1), .LEGACY_BOTH(LEGACY_BOTH)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s   (pin_s[g*GRP_W +: GRP_W]),
                .wr_evt  (bus_wr && hit[g] && (bank == BANK_EVT)),
                .wr_edge (bus_wr && hit[g] && (bank == BANK_EDGE)),
                .wr_dual (bus_wr && hit[g] && (bank == BANK_DUAL)),
                .wdata   (bus_wdata),
                .evt_o   (evt_a[g]),
                .edge_o  (edge_a[g]),
                .dual_o  (dual_a[g])
            );

            assign irq_bits[g*GRP_W +: GRP_W] = evt_a[g];
            assign irq_grp[g]                 = |evt_a[g];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (hit[g]) begin
                unique case (bank)
                    BANK_EVT:  bus_rdata = bus_rdata | evt_a[g];
                    BANK_EDGE: bus_rdata = bus_rdata | edge_a[g];
                    BANK_DUAL: bus_rdata = bus_rdata | dual_a[g];
                    default:   bus_rdata = bus_rdata;
                endcase
            end
        end
    end

    // R6: group offsets never overlap, so at most one group decodes
    p_one_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R7: a group summary line is high only while one of its pins is pending
    p_grp_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_grp) <= $countones(irq_bits));
endmodule

// File: tb/test_wkup_edge_ctrl.sv
module test_wkup_edge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 12;
    localparam int NP = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    rdata_a, rdata_b;
    logic [NP-1:0] irq_bits_a, irq_bits_b;
    logic [NG-1:0] irq_grp_a, irq_grp_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkup_edge_ctrl #(.NUM_GROUPS(NG), .SYNC_EN(1'b1), .LEGACY_BOTH(1'b0)) i_wkup_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .irq_bits(irq_bits_a), .irq_grp(irq_grp_a)
    );

    wkup_edge_ctrl #(.NUM_GROUPS(NG), .SYNC_EN(1'b1), .LEGACY_BOTH(1'b1)) i_wkup_legacy (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .irq_bits(irq_bits_b), .irq_grp(irq_grp_b)
    );

    function automatic logic [7:0] addr_of(input int bank, input int g);
        int o;
        o = (g < 5) ? g - 1 : (g - 4) * 4;
        return 8'(bank * 64 + o);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] da, output logic [7:0] db);
        @(negedge clk);
        bus_addr = a;
        #1;
        da = rdata_a; db = rdata_b;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] ra, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of all registers and outputs
        for (int g = 1; g <= NG; g++) begin
            for (int bk = 0; bk < 3; bk++) begin
                rd(addr_of(bk, g), ra, rb);
                chk("R1 reset register", {24'h0, ra}, 32'h0);
            end
        end
        chk("R1 irq_bits reset", {31'h0, |irq_bits_a}, 32'h0);
        chk("R1 irq_grp reset", {20'h0, irq_grp_a}, 32'h0);

        // Sweep: every group, every bit, modes 0=rise 1=fall 2=dual
        for (int g = 1; g <= NG; g++) begin
            for (int b = 0; b < 8; b++) begin
                for (int m = 0; m < 3; m++) begin
                    logic [7:0] bit_m;
                    logic [7:0] exp_a, exp_b;
                    bit compat;
                    bit_m  = 8'(1 << b);
                    compat = (m == 1) && (g == 7 || g == 10 || g == 12);
                    wr(addr_of(1, g), (m == 1) ? bit_m : 8'h00);
                    wr(addr_of(2, g), (m == 2) ? bit_m : 8'h00);
                    wr(addr_of(0, g), 8'hFF);
                    if (m == 1) begin
                        rd(addr_of(1, g), ra, rb);
                        chk("R6 edge-select readback", {24'h0, ra}, {24'h0, bit_m});
                    end
                    if (m == 2) begin
                        rd(addr_of(2, g), ra, rb);
                        chk("R6 dual-edge readback", {24'h0, ra}, {24'h0, bit_m});
                    end
                    // rising edge
                    @(negedge clk);
                    pin_in[(g-1)*8 + b] = 1'b1;
                    settle();
                    rd(addr_of(0, g), ra, rb);
                    exp_a = (m != 1) ? bit_m : 8'h00;
                    exp_b = (m != 1 || compat) ? bit_m : 8'h00;
                    chk((m == 2) ? "R3 dual rise" : "R2 rise", {24'h0, ra}, {24'h0, exp_a});
                    chk("R8 legacy rise", {24'h0, rb}, {24'h0, exp_b});
                    chk("R7 irq_bits rise", {24'h0, irq_bits_a[(g-1)*8 +: 8]}, {24'h0, exp_a});
                    chk("R7 irq_grp rise", {31'h0, irq_grp_a[g-1]}, {31'h0, |exp_a});
                    wr(addr_of(0, g), 8'hFF);
                    // falling edge
                    @(negedge clk);
                    pin_in[(g-1)*8 + b] = 1'b0;
                    settle();
                    rd(addr_of(0, g), ra, rb);
                    exp_a = (m != 0) ? bit_m : 8'h00;
                    exp_b = exp_a;
                    chk((m == 2) ? "R3 dual fall" : "R2 fall", {24'h0, ra}, {24'h0, exp_a});
                    chk("R8 legacy fall", {24'h0, rb}, {24'h0, exp_b});
                    chk("R7 irq_bits fall", {24'h0, irq_bits_b[(g-1)*8 +: 8]}, {24'h0, exp_b});
                    wr(addr_of(0, g), 8'hFF);
                    rd(addr_of(0, g), ra, rb);
                    chk("R4 write-1 clears", {24'h0, ra}, 32'h0);
                end
            end
        end

        // R3: dual bit overrides edge-select=1 on group 2 bit 3
        wr(addr_of(1, 2), 8'h08);
        wr(addr_of(2, 2), 8'h08);
        @(negedge clk); pin_in[8 + 3] = 1'b1;
        settle();
        rd(addr_of(0, 2), ra, rb);
        chk("R3 dual overrides edge-select", {24'h0, ra}, 32'h08);
        wr(addr_of(0, 2), 8'hFF);
        @(negedge clk); pin_in[8 + 3] = 1'b0;
        settle();
        wr(addr_of(0, 2), 8'hFF);

        // R4: writing 0 has no effect (group 3 bit 2, rise mode)
        wr(addr_of(1, 3), 8'h00);
        wr(addr_of(2, 3), 8'h00);
        @(negedge clk); pin_in[16 + 2] = 1'b1;
        settle();
        wr(addr_of(0, 3), 8'h00);
        rd(addr_of(0, 3), ra, rb);
        chk("R4 write 0 ignored", {24'h0, ra}, 32'h04);
        wr(addr_of(0, 3), 8'h04);
        @(negedge clk); pin_in[16 + 2] = 1'b0;
        settle();
        rd(addr_of(0, 3), ra, rb);
        chk("R2 falling ignored in rise mode", {24'h0, ra}, 32'h0);

        // R9: stable pin sets nothing
        repeat (10) @(posedge clk);
        chk("R9 idle pins no events", {31'h0, |irq_bits_a}, 32'h0);

        // R5: set and clear in the same cycle (group 1, bits 0 and 1)
        wr(addr_of(1, 1), 8'h00);
        wr(addr_of(2, 1), 8'h00);
        @(negedge clk); pin_in[1] = 1'b1;
        settle();
        @(negedge clk); pin_in[0] = 1'b1;   // lands before edge k
        @(posedge clk);                      // k
        @(posedge clk);                      // k+1
        @(negedge clk);
        bus_addr = addr_of(0, 1); bus_wdata = 8'hFF; bus_wr = 1'b1;
        @(posedge clk);                      // k+2: set and clear together
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R5 set wins over clear", {24'h0, rdata_a}, 32'h01);
        chk("R9 latency edge k+2", {31'h0, irq_bits_a[0]}, 32'h1);

        // R9: exact latency, visible after k+2 and not after k+1
        wr(addr_of(0, 1), 8'hFF);
        @(negedge clk); pin_in[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R9 not yet after k+1", {31'h0, irq_bits_a[2]}, 32'h0);
        @(negedge clk);
        chk("R9 set after k+2", {31'h0, irq_bits_a[2]}, 32'h1);
        pin_in[2:0] = 3'b000;
        pin_in[1] = 1'b0;
        settle();
        wr(addr_of(0, 1), 8'hFF);

        // R6: unmapped addresses read 0 and ignore writes
        wr(addr_of(1, 6), 8'h00);
        wr(8'h45, 8'hFF);
        wr(8'h3F, 8'hFF);
        wr(8'hC4, 8'hFF);
        rd(8'h45, ra, rb);
        chk("R6 gap offset reads 0", {24'h0, ra}, 32'h0);
        rd(8'hC4, ra, rb);
        chk("R6 bank 3 reads 0", {24'h0, ra}, 32'h0);
        rd(addr_of(1, 6), ra, rb);
        chk("R6 neighbour group 6 untouched", {24'h0, ra}, 32'h0);
        rd(addr_of(1, 5), ra, rb);
        chk("R6 neighbour group 5 untouched", {24'h0, ra}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule